// File: doc/BRIEF.md
# Command-Byte Register Front End

This block is the register side of a byte-serial sensor interface. It sits behind a serial slave shifter that already handles bit framing, device addressing and acknowledges, and receives three one-cycle strobes from it: a transaction start, a received byte, and a byte-taken strobe for reads. The first byte written after a transaction start is treated as a command when its top bit is set. A command either loads a register pointer together with a transfer type (same register every byte, or pointer advancing after every byte) or triggers a special function. A first byte without the top bit is stored as data at the pointer left by the last valid command.

The block holds the configuration registers and drives them out as plain control outputs for the measurement engine. It also presents a read-only identity byte, a status byte, and four 16-bit channel results latched from the engine. Each channel has a shadow byte. Reading a channel's low byte captures that channel's high byte, so a low-then-high read pair stays coherent even when a new result arrives between the two reads.

Top module: `cbr_regfront`

## Requirements
- R1: After reset, the enable, threshold, persistence, configuration and gain registers are 0x00, the integration-time and wait-time registers are 0xFF, and the status byte reads 0x00.
- R2: When the first byte written after a transaction start has bit 7 set and bits 6:5 equal to 00 or 01, bits 4:0 become the register pointer and the byte is not stored in any register.
- R3: With transfer type 00 the pointer stays fixed, so successive data writes and reads in one or more transactions all hit the same register.
- R4: With transfer type 01 the pointer advances by one after every data byte written or read, and it wraps from 0x1F to 0x00.
- R5: A command byte with bits 6:5 equal to 11 and bits 4:0 equal to 00110 clears the pending interrupt flag without changing the pointer or transfer type; other special codes and commands with bits 6:5 equal to 10 change nothing.
- R6: When the first byte of a transaction has bit 7 clear, it is stored as data at the pointer and then follows the stored transfer type.
- R7: A read with no command in its transaction returns the register at the pointer left by the previous command.
- R8: The writable registers are enable 0x00, integration time 0x01, wait time 0x03, threshold low 0x04 and 0x05, threshold high 0x06 and 0x07 (low byte at the lower address), persistence 0x0C, configuration 0x0D and gain 0x0F; writes anywhere else are ignored, addresses without a register read 0x00, and the identity byte at 0x12 reads 0x44.
- R9: The status byte at 0x13 carries the interrupt flag in bit 4; an interrupt event sets the flag, which holds until cleared, and an event in the same cycle as a clear leaves the flag set.
- R10: A result load captures all four channel results and sets the sticky valid flag in status bit 0; the channels are clear, red, green and blue at low-byte addresses 0x14, 0x16, 0x18 and 0x1A with each high byte at the next address.
- R11: Reading a channel's low byte copies that channel's high byte into its shadow, and reading the high-byte address returns the shadow, even after a newer result has been loaded.
- R12: The control outputs always equal the current contents of the writable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xact_start | input | 1 | One-cycle pulse at the start of a bus transaction |
| wr_valid | input | 1 | One-cycle pulse: wr_byte holds a received byte |
| wr_byte | input | 8 | Received byte |
| rd_strobe | input | 1 | One-cycle pulse: rd_byte has been taken by the shifter |
| rd_byte | output | 8 | Byte at the current pointer |
| res_load | input | 1 | One-cycle pulse: new channel results on res_data |
| res_data | input | 64 | Channel results, clear in bits 15:0, then red, green, blue |
| int_event | input | 1 | One-cycle pulse: threshold logic raises the interrupt |
| irq_pending | output | 1 | Interrupt flag |
| ctl_enable | output | 8 | Enable register |
| ctl_itime | output | 8 | Integration-time register |
| ctl_wtime | output | 8 | Wait-time register |
| ctl_thr_lo | output | 16 | Low threshold |
| ctl_thr_hi | output | 16 | High threshold |
| ctl_pers | output | 8 | Persistence register |
| ctl_cfg | output | 8 | Configuration register |
| ctl_gain | output | 8 | Gain register |

## Verification
The hardest situation to reach is a result load landing between the low and high reads of one channel, because the bench must split the pair across two commanded transactions and inject the new result in the gap; the bench does exactly that and expects the old high byte, then repeats the pair to see the new one. A second awkward case is an interrupt event and the clear command in the same cycle, which the bench produces by raising the event while the clear byte is being written. Special codes that must do nothing are observed by reading the status byte with a command-less read, which proves both that the flag survived and that the pointer did not move.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int ADDR_W = 5;
    localparam int CH_W   = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        XF_REPEAT  = 2'b00,
        XF_INCR    = 2'b01,
        XF_RSVD    = 2'b10,
        XF_SPECIAL = 2'b11
    } xfer_e;

    typedef struct packed {
        logic  is_cmd;
        xfer_e kind;
        addr_t field;
    } cmd_t;

    typedef struct packed {
        logic [7:0]  enable;
        logic [7:0]  itime;
        logic [7:0]  wtime;
        logic [15:0] thr_lo;
        logic [15:0] thr_hi;
        logic [7:0]  pers;
        logic [7:0]  cfg;
        logic [7:0]  gain;
    } ctrl_t;

    localparam addr_t A_ENABLE = 5'h00;
    localparam addr_t A_ITIME  = 5'h01;
    localparam addr_t A_WTIME  = 5'h03;
    localparam addr_t A_TLO_L  = 5'h04;
    localparam addr_t A_TLO_H  = 5'h05;
    localparam addr_t A_THI_L  = 5'h06;
    localparam addr_t A_THI_H  = 5'h07;
    localparam addr_t A_PERS   = 5'h0C;
    localparam addr_t A_CFG    = 5'h0D;
    localparam addr_t A_GAIN   = 5'h0F;
    localparam addr_t A_IDENT  = 5'h12;
    localparam addr_t A_STATUS = 5'h13;
    localparam addr_t A_DATA   = 5'h14;

    localparam addr_t SF_INT_CLR = 5'b00110;

    function automatic cmd_t split_cmd(input logic [7:0] b);
        cmd_t c;
        c.is_cmd = b[7];
        c.kind   = xfer_e'(b[6:5]);
        c.field  = b[4:0];
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input logic irq, input logic valid);
        return {3'b000, irq, 3'b000, valid};
    endfunction

endpackage

// File: rtl/cbr_ptr.sv
module cbr_ptr
    import cbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xact_start,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       rd_strobe,
    output addr_t      addr_o,
    output logic       incr_o,
    output logic       data_we_o,
    output logic       sf_clr_o
);
    logic  first_q;
    addr_t addr_q;
    logic  incr_q;
    cmd_t  cmd;
    logic  take_cmd;
    logic  load_ptr;
    logic  step;

    always_comb begin
        cmd       = split_cmd(wr_byte);
        take_cmd  = wr_valid && first_q && cmd.is_cmd;
        load_ptr  = take_cmd && (cmd.kind == XF_REPEAT || cmd.kind == XF_INCR);
        data_we_o = wr_valid && !take_cmd;
        sf_clr_o  = take_cmd && cmd.kind == XF_SPECIAL && cmd.field == SF_INT_CLR;
        step      = incr_q && (data_we_o || rd_strobe);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            addr_q  <= '0;
            incr_q  <= 1'b0;
        end else begin
            if (xact_start)
                first_q <= 1'b1;
            else if (wr_valid || rd_strobe)
                first_q <= 1'b0;

            if (load_ptr) begin
                addr_q <= cmd.field;
                incr_q <= (cmd.kind == XF_INCR);
            end else if (step) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign addr_o = addr_q;
    assign incr_o = incr_q;
endmodule

// File: rtl/cbr_ctrl_regs.sv
module cbr_ctrl_regs
    import cbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  addr_t      addr,
    input  logic [7:0] wdata,
    input  logic       int_event,
    input  logic       int_clr,
    output ctrl_t      ctrl_o,
    output logic       irq_o
);
    ctrl_t regs_q;
    logic  irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q       <= '0;
            regs_q.itime <= 8'hFF;
            regs_q.wtime <= 8'hFF;
        end else if (we) begin
            unique case (addr)
                A_ENABLE: regs_q.enable      <= wdata;
                A_ITIME:  regs_q.itime       <= wdata;
                A_WTIME:  regs_q.wtime       <= wdata;
                A_TLO_L:  regs_q.thr_lo[7:0] <= wdata;
                A_TLO_H:  regs_q.thr_lo[15:8] <= wdata;
                A_THI_L:  regs_q.thr_hi[7:0] <= wdata;
                A_THI_H:  regs_q.thr_hi[15:8] <= wdata;
                A_PERS:   regs_q.pers        <= wdata;
                A_CFG:    regs_q.cfg         <= wdata;
                A_GAIN:   regs_q.gain        <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (int_event)
            irq_q <= 1'b1;
        else if (int_clr)
            irq_q <= 1'b0;
    end

    assign ctrl_o = regs_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/cbr_result_bank.sv
module cbr_result_bank
    import cbr_pkg::*;
#(
    parameter int NUM_CH = 4
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [NUM_CH*CH_W-1:0] res_data,
    input  logic                   rd_strobe,
    input  addr_t                  addr,
    output logic [7:0]             rd_data,
    output logic                   valid_o
);
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0] ch_q  [NUM_CH];
    logic [7:0]      shd_q [NUM_CH];
    logic            valid_q;
    addr_t           off;
    logic            in_range;
    logic            hi_sel;
    logic [SEL_W-1:0] sel;

    always_comb begin
        off      = addr - A_DATA;
        in_range = (addr >= A_DATA) && (off < ADDR_W'(2 * NUM_CH));
        hi_sel   = off[0];
        sel      = off[SEL_W:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            for (int g = 0; g < NUM_CH; g++) begin
                ch_q[g]  <= '0;
                shd_q[g] <= '0;
            end
        end else begin
            if (load) valid_q <= 1'b1;
            for (int g = 0; g < NUM_CH; g++) begin
                if (load)
                    ch_q[g] <= res_data[g*CH_W +: CH_W];
                if (rd_strobe && in_range && !hi_sel && sel == SEL_W'(g))
                    shd_q[g] <= ch_q[g][15:8];
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int g = 0; g < NUM_CH; g++) begin
            if (in_range && sel == SEL_W'(g))
                rd_data = hi_sel ? shd_q[g] : ch_q[g][7:0];
        end
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/cbr_regfront.sv
module cbr_regfront
    import cbr_pkg::*;
#(
    parameter int         NUM_CH   = 4,
    parameter logic [7:0] ID_VALUE = 8'h44
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   xact_start,
    input  logic                   wr_valid,
    input  logic [7:0]             wr_byte,
    input  logic                   rd_strobe,
    output logic [7:0]             rd_byte,
    input  logic                   res_load,
    input  logic [NUM_CH*CH_W-1:0] res_data,
    input  logic                   int_event,
    output logic                   irq_pending,
    output logic [7:0]             ctl_enable,
    output logic [7:0]             ctl_itime,
    output logic [7:0]             ctl_wtime,
    output logic [15:0]            ctl_thr_lo,
    output logic [15:0]            ctl_thr_hi,
    output logic [7:0]             ctl_pers,
    output logic [7:0]             ctl_cfg,
    output logic [7:0]             ctl_gain
);
    addr_t      ptr_addr;
    logic       ptr_incr;
    logic       data_we;
    logic       sf_clr;
    ctrl_t      ctrl;
    logic       valid_flag;
    logic [7:0] bank_rd;

    cbr_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .xact_start (xact_start),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .rd_strobe  (rd_strobe),
        .addr_o     (ptr_addr),
        .incr_o     (ptr_incr),
        .data_we_o  (data_we),
        .sf_clr_o   (sf_clr)
    );

    cbr_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (data_we),
        .addr      (ptr_addr),
        .wdata     (wr_byte),
        .int_event (int_event),
        .int_clr   (sf_clr),
        .ctrl_o    (ctrl),
        .irq_o     (irq_pending)
    );

    cbr_result_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load      (res_load),
        .res_data  (res_data),
        .rd_strobe (rd_strobe),
        .addr      (ptr_addr),
        .rd_data   (bank_rd),
        .valid_o   (valid_flag)
    );

    always_comb begin
        unique case (ptr_addr)
            A_ENABLE: rd_byte = ctrl.enable;
            A_ITIME:  rd_byte = ctrl.itime;
            A_WTIME:  rd_byte = ctrl.wtime;
            A_TLO_L:  rd_byte = ctrl.thr_lo[7:0];
            A_TLO_H:  rd_byte = ctrl.thr_lo[15:8];
            A_THI_L:  rd_byte = ctrl.thr_hi[7:0];
            A_THI_H:  rd_byte = ctrl.thr_hi[15:8];
            A_PERS:   rd_byte = ctrl.pers;
            A_CFG:    rd_byte = ctrl.cfg;
            A_GAIN:   rd_byte = ctrl.gain;
            A_IDENT:  rd_byte = ID_VALUE;
            A_STATUS: rd_byte = status_byte(irq_pending, valid_flag);
            default:  rd_byte = bank_rd;
        endcase
    end

    assign ctl_enable = ctrl.enable;
    assign ctl_itime  = ctrl.itime;
    assign ctl_wtime  = ctrl.wtime;
    assign ctl_thr_lo = ctrl.thr_lo;
    assign ctl_thr_hi = ctrl.thr_hi;
    assign ctl_pers   = ctrl.pers;
    assign ctl_cfg    = ctrl.cfg;
    assign ctl_gain   = ctrl.gain;
endmodule

// File: rtl/cbr_regfront_chk.sv
module cbr_regfront_chk
    import cbr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  int_event,
    input logic  irq_pending,
    input logic  sf_clr,
    input addr_t ptr_addr,
    input logic  ptr_incr,
    input logic  data_we,
    input logic  rd_strobe,
    input logic  res_load,
    input logic  valid_flag
);
    // R9: an event always leaves the flag set
    a_r9_irq_set: assert property (@(posedge clk) disable iff (rst)
        int_event |=> irq_pending);

    // R5: the clear command drops the flag when no event competes
    a_r5_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (sf_clr && !int_event) |=> !irq_pending);

    // R3: fixed pointer in same-register mode
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!ptr_incr && (data_we || rd_strobe)) |=> $stable(ptr_addr));

    // R4: pointer advances by one with wrap
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (ptr_incr && (data_we || rd_strobe)) |=> ptr_addr == $past(ptr_addr) + 5'd1);

    // R10: a load sets the valid flag
    a_r10_valid_set: assert property (@(posedge clk) disable iff (rst)
        res_load |=> valid_flag);

    // R10: the valid flag is sticky
    a_r10_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid_flag |=> valid_flag);
endmodule

bind cbr_regfront cbr_regfront_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .int_event   (int_event),
    .irq_pending (irq_pending),
    .sf_clr      (sf_clr),
    .ptr_addr    (ptr_addr),
    .ptr_incr    (ptr_incr),
    .data_we     (data_we),
    .rd_strobe   (rd_strobe),
    .res_load    (res_load),
    .valid_flag  (valid_flag)
);

// File: tb/sim_cbr_regfront.sv
module sim_cbr_regfront;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xact_start = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rd_byte;
    logic        res_load = 1'b0;
    logic [63:0] res_data = '0;
    logic        int_event = 1'b0;
    logic        irq_pending;
    logic [7:0]  ctl_enable, ctl_itime, ctl_wtime, ctl_pers, ctl_cfg, ctl_gain;
    logic [15:0] ctl_thr_lo, ctl_thr_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cbr_regfront u0 (
        .clk(clk), .rst(rst), .xact_start(xact_start), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
        .res_load(res_load), .res_data(res_data), .int_event(int_event),
        .irq_pending(irq_pending), .ctl_enable(ctl_enable), .ctl_itime(ctl_itime),
        .ctl_wtime(ctl_wtime), .ctl_thr_lo(ctl_thr_lo), .ctl_thr_hi(ctl_thr_hi),
        .ctl_pers(ctl_pers), .ctl_cfg(ctl_cfg), .ctl_gain(ctl_gain)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_x();
        @(negedge clk); xact_start = 1'b1;
        @(negedge clk); xact_start = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_byte = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk); rd_strobe = 1'b1;
        #1 b = rd_byte;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic read_at(input logic [7:0] cmd, output logic [7:0] b);
        start_x(); put(cmd); start_x(); get(b);
    endtask

    task automatic pulse_event();
        @(negedge clk); int_event = 1'b1;
        @(negedge clk); int_event = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1 enable", 16'(ctl_enable), 16'h00);
        chk("R1 itime", 16'(ctl_itime), 16'hFF);
        chk("R1 wtime", 16'(ctl_wtime), 16'hFF);
        chk("R1 thr_lo", ctl_thr_lo, 16'h0000);
        chk("R1 thr_hi", ctl_thr_hi, 16'h0000);
        chk("R1 pers/cfg/gain", {ctl_pers, ctl_cfg | ctl_gain}, 16'h0000);
        read_at(8'h93, b);
        chk("R1 status", 16'(b), 16'h00);
        read_at(8'h81, b);
        chk("R1 itime read", 16'(b), 16'hFF);
    endtask

    task automatic t_repeat();
        logic [7:0] b;
        start_x(); put(8'h80); put(8'h0B); put(8'h05);
        chk("R3 enable last write", 16'(ctl_enable), 16'h05);
        chk("R2 command not stored", 16'(ctl_itime), 16'hFF);
        start_x(); get(b);
        chk("R7 read without command", 16'(b), 16'h05);
        get(b);
        chk("R3 second read same reg", 16'(b), 16'h05);
    endtask

    task automatic t_autoinc();
        logic [7:0] b;
        start_x(); put(8'hA4); put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        chk("R4 thr_lo", ctl_thr_lo, 16'h2211);
        chk("R4 thr_hi", ctl_thr_hi, 16'h4433);
        start_x(); put(8'hA4);
        for (int i = 0; i < 4; i++) begin
            get(b);
            chk("R4 read sequence", 16'(b), 16'(8'h11 * (i + 1)));
        end
        start_x(); put(8'hBF); get(b);
        chk("R8 unmapped read 0x1F", 16'(b), 16'h00);
        get(b);
        chk("R4 wrap to 0x00", 16'(b), 16'h05);
    endtask

    task automatic t_nocmd();
        start_x(); put(8'h8F);
        start_x(); put(8'h03);
        chk("R6 gain via data-first", 16'(ctl_gain), 16'h03);
        start_x(); put(8'h02);
        chk("R6 gain again", 16'(ctl_gain), 16'h02);
        start_x(); put(8'hA4);
        start_x(); put(8'h66); put(8'h77);
        chk("R6 incr mode data-first", ctl_thr_lo, 16'h7766);
    endtask

    task automatic t_irq();
        logic [7:0] b;
        pulse_event();
        chk("R9 irq pin", 16'(irq_pending), 16'h1);
        read_at(8'h93, b);
        chk("R9 status bit4", 16'(b), 16'h10);
        start_x(); put(8'hE5); start_x(); get(b);
        chk("R5 other code no effect", 16'(b), 16'h10);
        start_x(); put(8'hC2); start_x(); get(b);
        chk("R5 reserved type no effect", 16'(b), 16'h10);
        start_x(); put(8'hE6); start_x(); get(b);
        chk("R5 clear keeps pointer", 16'(b), 16'h00);
        start_x();
        @(negedge clk); wr_valid = 1'b1; wr_byte = 8'hE6; int_event = 1'b1;
        @(negedge clk); wr_valid = 1'b0; int_event = 1'b0;
        chk("R9 set wins over clear", 16'(irq_pending), 16'h1);
        start_x(); put(8'hE6);
        chk("R5 clear", 16'(irq_pending), 16'h0);
    endtask

    task automatic t_data();
        logic [7:0] b;
        logic [7:0] exp_b [8] = '{8'h34, 8'h12, 8'h78, 8'h56, 8'hBC, 8'h9A, 8'hF0, 8'hDE};
        @(negedge clk); res_load = 1'b1; res_data = 64'hDEF0_9ABC_5678_1234;
        @(negedge clk); res_load = 1'b0;
        read_at(8'h93, b);
        chk("R10 valid bit0", 16'(b), 16'h01);
        start_x(); put(8'hB4);
        for (int i = 0; i < 8; i++) begin
            get(b);
            chk("R10/R11 channel bytes", 16'(b), 16'(exp_b[i]));
        end
        read_at(8'h94, b);
        chk("R11 low byte", 16'(b), 16'h34);
        @(negedge clk); res_load = 1'b1; res_data = 64'h1111_2222_3333_AAAA;
        @(negedge clk); res_load = 1'b0;
        read_at(8'h95, b);
        chk("R11 shadow holds old high", 16'(b), 16'h12);
        read_at(8'h94, b);
        chk("R11 new low", 16'(b), 16'hAA);
        read_at(8'h95, b);
        chk("R11 new high", 16'(b), 16'hAA);
        read_at(8'h93, b);
        chk("R10 valid sticky", 16'(b), 16'h01);
    endtask

    task automatic t_readonly();
        logic [7:0] b;
        start_x(); put(8'h92); put(8'h55);
        start_x(); get(b);
        chk("R8 ident unchanged", 16'(b), 16'h44);
        start_x(); put(8'h82); put(8'h77);
        start_x(); get(b);
        chk("R8 unmapped 0x02", 16'(b), 16'h00);
        start_x(); put(8'h94); put(8'h99);
        start_x(); get(b);
        chk("R8 data write ignored", 16'(b), 16'hAA);
        start_x(); put(8'h8D); put(8'h02);
        chk("R12 cfg output", 16'(ctl_cfg), 16'h02);
        start_x(); put(8'h8C); put(8'h05);
        chk("R12 pers output", 16'(ctl_pers), 16'h05);
        start_x(); put(8'h83); put(8'hAB);
        chk("R12 wtime output", 16'(ctl_wtime), 16'hAB);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_repeat();
        t_autoinc();
        t_nocmd();
        t_irq();
        t_data();
        t_readonly();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule